// File: doc/BRIEF.md
# Incremental Sigma-Delta Decimator with Digital Double Sampling

This block turns the one-bit output of a column sigma-delta modulator into a multi-bit pixel code. A start strobe clears two cascaded accumulators, so every conversion begins from zero and behaves as an incremental converter. The first accumulator counts the ones in the bitstream. The second accumulator adds the first one's updated value on each sampled cycle. After a programmed number of samples the block pulses a done flag and saturates the result to 13 bits.

Each pixel is converted twice. A conversion tagged as the reset level is kept in a holding register. The conversion tagged as the signal level that follows has the held value subtracted from it. The signed difference is clamped to the 13-bit two's complement range, driven on a parallel output and loaded into a 13-stage shift chain. The chain is read out serially, most significant bit first, one bit per scan enable.

Top module: `incr_sd_decim`

## Requirements
- R1: While reset is asserted and just after it is released, `done` is 0, `diff_code` is 0 and `scan_out` is 0.
- R2: A start strobe clears both accumulators. On each later sampled cycle, the first accumulator adds `mod_bit` and the second accumulator adds the first accumulator's updated value. N ones in a row therefore give N(N+1)/2, and alternating 1,0 over 100 samples gives 2550.
- R3: `osr` is captured on the start cycle and clamped to the range 100..128. The bit is sampled on each of the next `osr` clock edges. `done` stays low until the last of those edges and is high in the cycle that follows it.
- R4: `done` is high for exactly one cycle per finished conversion.
- R5: A conversion result above 8191 saturates to 8191. For example, 128 ones gives 8191 and not 8256 or a wrapped value.
- R6: A conversion with `phase_sig` = 0 (reset level) stores its result in the holding register and leaves `diff_code` and the shift chain unchanged.
- R7: A conversion with `phase_sig` = 1 (signal level) sets `diff_code` to its result minus the held value, clamped to -4096..4095 in 13-bit two's complement. The new value is visible in the cycle where `done` is high.
- R8: The shift chain is loaded with `diff_code` when R7 updates it, and `scan_out` shows chain bit 12. Each cycle with `scan_en` high shifts the chain up one place and fills with 0, so after 13 shifts `scan_out` reads 0.
- R9: A start strobe during a conversion abandons the old conversion without a done pulse. The new conversion runs a full count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one modulator bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the accumulators and begins a conversion |
| phase_sig | input | 1 | 0 = reset-level conversion, 1 = signal-level conversion |
| osr | input | 8 | Requested samples per conversion, clamped to 100..128 |
| mod_bit | input | 1 | Modulator bitstream |
| scan_en | input | 1 | Shifts the readout chain by one bit |
| diff_code | output | 13 | Signed signal-minus-reset code |
| done | output | 1 | One-cycle pulse at the end of a conversion |
| scan_out | output | 1 | Serial readout bit, MSB first |

## Verification
On every cycle the assertions check the following: the accumulators are zero after a start, the first accumulator never exceeds the sample count, and the captured oversampling count stays in range while busy. They also check that done never lasts two cycles, that the holding and difference registers change only on their own phase, and that the chain shifts with zero fill. The arithmetic can only be shown by the bench's scenarios: the second-order sum for each bit pattern, saturation at 8191, the clamped difference, and the exact cycle of done for clamped and restarted conversions.

// File: rtl/isd_pkg.sv
package isd_pkg;

  // Default geometry of the decimator
  localparam int DEF_OSR_MIN = 100;
  localparam int DEF_OSR_MAX = 128;
  localparam int DEF_OUT_W   = 13;

  // Which level of the pixel a conversion measures
  typedef enum logic {
    PH_RESET  = 1'b0,
    PH_SIGNAL = 1'b1
  } phase_e;

endpackage

// File: rtl/isd_accum.sv
module isd_accum
  import isd_pkg::*;
#(
  parameter int OSR_MIN = DEF_OSR_MIN,
  parameter int OSR_MAX = DEF_OSR_MAX,
  parameter int OUT_W   = DEF_OUT_W,
  parameter int CNT_W   = $clog2(OSR_MAX + 1),
  parameter int ACC2_W  = $clog2(OSR_MAX * (OSR_MAX + 1) / 2 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] osr_i,
  input  logic             bit_i,
  output logic             fin_o,
  output phase_e           phase_o,
  output logic [OUT_W-1:0] res_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] MINV = CNT_W'(OSR_MIN);
  localparam logic [CNT_W-1:0] MAXV = CNT_W'(OSR_MAX);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  osr_q, osr_d, osr_clamped;
  logic [CNT_W-1:0]  acc1_q, acc1_d;
  logic [ACC2_W-1:0] acc2_q, acc2_d;
  phase_e            phase_q, phase_d;
  logic              done_q, done_d;
  logic              fin;

  // Next-state logic
  always_comb begin
    if (osr_i < MINV)      osr_clamped = MINV;
    else if (osr_i > MAXV) osr_clamped = MAXV;
    else                   osr_clamped = osr_i;

    busy_d  = busy_q;
    cnt_d   = cnt_q;
    osr_d   = osr_q;
    acc1_d  = acc1_q;
    acc2_d  = acc2_q;
    phase_d = phase_q;
    fin     = busy_q && !start_i && (cnt_q == osr_q - 1'b1);

    if (start_i) begin
      busy_d  = 1'b1;
      cnt_d   = '0;
      acc1_d  = '0;
      acc2_d  = '0;
      osr_d   = osr_clamped;
      phase_d = phase_i;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
      acc1_d = acc1_q + CNT_W'(bit_i);
      acc2_d = acc2_q + ACC2_W'(acc1_d);
      if (fin) busy_d = 1'b0;
    end
    done_d = fin;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      osr_q   <= MINV;
      acc1_q  <= '0;
      acc2_q  <= '0;
      phase_q <= PH_RESET;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      osr_q   <= osr_d;
      acc1_q  <= acc1_d;
      acc2_q  <= acc2_d;
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  // Saturate the final sum to the output width when it can exceed it
  generate
    if (ACC2_W > OUT_W) begin : g_sat
      localparam logic [ACC2_W-1:0] SATV = ACC2_W'({OUT_W{1'b1}});
      assign res_o = (acc2_d > SATV) ? {OUT_W{1'b1}} : acc2_d[OUT_W-1:0];
    end else begin : g_pass
      assign res_o = OUT_W'(acc2_d);
    end
  endgenerate

  assign fin_o   = fin;
  assign phase_o = phase_q;
  assign done_o  = done_q;

  // R2
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (acc1_q == '0 && acc2_q == '0 && cnt_q == '0));

  // R2
  acc1_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc1_q <= cnt_q);

  // R3
  osr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (osr_q >= MINV && osr_q <= MAXV));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/isd_cds.sv
module isd_cds
  import isd_pkg::*;
#(
  parameter int OUT_W = DEF_OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin_i,
  input  phase_e           phase_i,
  input  logic [OUT_W-1:0] res_i,
  output logic [OUT_W-1:0] diff_o,
  output logic             load_o
);

  localparam int DW = OUT_W + 1;
  localparam logic signed [DW-1:0] POS_LIM = DW'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [DW-1:0] NEG_LIM = -DW'(2 ** (OUT_W - 1));

  logic [OUT_W-1:0]        hold_q, hold_d;
  logic [OUT_W-1:0]        diff_q, diff_d;
  logic signed [DW-1:0]    raw;
  logic [OUT_W-1:0]        clamped;
  logic                    take_ref, take_sig;

  always_comb begin
    take_ref = fin_i && (phase_i == PH_RESET);
    take_sig = fin_i && (phase_i == PH_SIGNAL);
    raw      = $signed({1'b0, res_i}) - $signed({1'b0, hold_q});
    if (raw > POS_LIM)      clamped = POS_LIM[OUT_W-1:0];
    else if (raw < NEG_LIM) clamped = NEG_LIM[OUT_W-1:0];
    else                    clamped = raw[OUT_W-1:0];
    hold_d = take_ref ? res_i   : hold_q;
    diff_d = take_sig ? clamped : diff_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      diff_q <= '0;
    end else begin
      hold_q <= hold_d;
      diff_q <= diff_d;
    end
  end

  assign diff_o = diff_q;
  assign load_o = take_sig;

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin_i && phase_i == PH_RESET) |=> $stable(hold_q));

  // R7
  diff_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin_i && phase_i == PH_SIGNAL) |=> $stable(diff_q));

endmodule

// File: rtl/isd_scan.sv
module isd_scan #(
  parameter int SCAN_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SCAN_W-1:0] data_i,
  input  logic              shift_i,
  output logic              scan_o
);

  logic [SCAN_W-1:0] chain_q, chain_d;

  always_comb begin
    if (load_i)       chain_d = data_i;
    else if (shift_i) chain_d = {chain_q[SCAN_W-2:0], 1'b0};
    else              chain_d = chain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign scan_o = chain_q[SCAN_W-1];

  // R8
  shift_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (chain_q == {$past(chain_q[SCAN_W-2:0]), 1'b0}));

  // R8
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (chain_q == $past(data_i)));

endmodule

// File: rtl/incr_sd_decim.sv
module incr_sd_decim
  import isd_pkg::*;
#(
  parameter int OSR_MIN = DEF_OSR_MIN,
  parameter int OSR_MAX = DEF_OSR_MAX,
  parameter int OUT_W   = DEF_OUT_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          phase_sig,
  input  logic [$clog2(OSR_MAX+1)-1:0]  osr,
  input  logic                          mod_bit,
  input  logic                          scan_en,
  output logic [OUT_W-1:0]              diff_code,
  output logic                          done,
  output logic                          scan_out
);

  localparam int CNT_W  = $clog2(OSR_MAX + 1);
  localparam int ACC2_W = $clog2(OSR_MAX * (OSR_MAX + 1) / 2 + 1);

  logic             fin;
  phase_e           conv_phase;
  logic [OUT_W-1:0] res;
  logic             chain_load;

  isd_accum #(
    .OSR_MIN (OSR_MIN),
    .OSR_MAX (OSR_MAX),
    .OUT_W   (OUT_W),
    .CNT_W   (CNT_W),
    .ACC2_W  (ACC2_W)
  ) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .phase_i (phase_e'(phase_sig)),
    .osr_i   (osr),
    .bit_i   (mod_bit),
    .fin_o   (fin),
    .phase_o (conv_phase),
    .res_o   (res),
    .done_o  (done)
  );

  isd_cds #(
    .OUT_W (OUT_W)
  ) u_cds (
    .clk     (clk),
    .rst_n   (rst_n),
    .fin_i   (fin),
    .phase_i (conv_phase),
    .res_i   (res),
    .diff_o  (diff_code),
    .load_o  (chain_load)
  );

  isd_scan #(
    .SCAN_W (OUT_W)
  ) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (chain_load),
    .data_i  (diff_code_next(chain_load, diff_code)),
    .shift_i (scan_en),
    .scan_o  (scan_out)
  );

  // The chain loads the same value the difference register takes
  function automatic logic [OUT_W-1:0] diff_code_next(input logic ld,
                                                     input logic [OUT_W-1:0] cur);
    return ld ? u_cds.clamped : cur;
  endfunction

  // R9
  no_done_on_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

endmodule

// File: tb/incr_sd_decim_test.sv
module incr_sd_decim_test;

  localparam int CLK_P = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        phase_sig;
  logic [7:0]  osr;
  logic        mod_bit;
  logic        scan_en;
  logic [12:0] diff_code;
  logic        done;
  logic        scan_out;

  int n_chk = 0;
  int n_bad = 0;
  int hold_m = 0;
  int diff_m = 0;
  bit ended = 0;

  always #(CLK_P / 2) clk = ~clk;

  incr_sd_decim uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .phase_sig (phase_sig),
    .osr       (osr),
    .mod_bit   (mod_bit),
    .scan_en   (scan_en),
    .diff_code (diff_code),
    .done      (done),
    .scan_out  (scan_out)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int clamp_diff(input int v);
    if (v > 4095)  return 4095;
    if (v < -4096) return -4096;
    return v;
  endfunction

  // kind: 0 zeros, 1 ones, 2 alternating from 1, 3 random with density dens/256
  task automatic run_conv(input bit ph, input int osr_req, input int kind, input int dens);
    int n, a1, a2, res;
    bit b;
    n  = (osr_req < 100) ? 100 : (osr_req > 128) ? 128 : osr_req;
    a1 = 0;
    a2 = 0;
    @(negedge clk);
    start     = 1'b1;
    phase_sig = ph;
    osr       = 8'(osr_req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) chk("R3 done low before last sample", int'(done), 0);
      start = 1'b0;
      case (kind)
        0:       b = 1'b0;
        1:       b = 1'b1;
        2:       b = (i % 2 == 0);
        default: b = (($urandom % 256) < dens);
      endcase
      mod_bit = b;
      a1 += int'(b);
      a2 += a1;
    end
    @(negedge clk);
    chk("R3 done after last sample", int'(done), 1);
    res = (a2 > 8191) ? 8191 : a2;
    if (ph) begin
      diff_m = clamp_diff(res - hold_m);
      chk("R7 difference code", int'($signed(diff_code)), diff_m);
      chk("R8 scan_out shows MSB after load", int'(scan_out), int'(diff_m[12]));
    end else begin
      hold_m = res;
      chk("R6 diff unchanged on reset phase", int'($signed(diff_code)), diff_m);
    end
    mod_bit = 1'b0;
    @(negedge clk);
    chk("R4 done single cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; phase_sig = 1'b0; osr = 8'd100;
    mod_bit = 1'b0; scan_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 diff in reset", int'(diff_code), 0);
    chk("R1 scan in reset", int'(scan_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 diff after reset", int'(diff_code), 0);
  endtask

  // R2: exact second-order sums
  task automatic t_patterns();
    run_conv(1'b0, 100, 0, 0);
    run_conv(1'b1, 100, 2, 0);
    chk("R2 alternating sum 2550", diff_m, 2550);
    run_conv(1'b0, 100, 3, 20);
    run_conv(1'b1, 100, 3, 40);
    run_conv(1'b0, 128, 3, 90);
    run_conv(1'b1, 128, 3, 60);
    run_conv(1'b0, 128, 3, 30);
    run_conv(1'b1, 128, 3, 200);
  endtask

  // R5 and R7 clamping
  task automatic t_saturate();
    run_conv(1'b0, 100, 1, 0);
    run_conv(1'b1, 128, 1, 0);
    chk("R5 saturated 8191 minus 5050", diff_m, 3141);
    run_conv(1'b0, 128, 1, 0);
    run_conv(1'b1, 100, 0, 0);
    chk("R7 negative clamp", int'($signed(diff_code)), -4096);
    run_conv(1'b0, 100, 0, 0);
    run_conv(1'b1, 100, 1, 0);
    chk("R7 positive clamp", int'($signed(diff_code)), 4095);
  endtask

  // R3 clamping of the requested count
  task automatic t_osr_clamp();
    run_conv(1'b0, 20, 1, 0);
    run_conv(1'b1, 250, 1, 0);
    chk("R3 clamped counts give 3141", int'($signed(diff_code)), 3141);
  endtask

  // R8 serial readout
  task automatic t_scan();
    logic [12:0] d;
    run_conv(1'b0, 100, 0, 0);
    run_conv(1'b1, 100, 2, 0);
    d = 13'(diff_m);
    @(negedge clk);
    chk("R8 scan bit 12", int'(scan_out), int'(d[12]));
    scan_en = 1'b1;
    for (int i = 1; i < 13; i++) begin
      @(negedge clk);
      chk("R8 scan bit", int'(scan_out), int'(d[12-i]));
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 zero fill", int'(scan_out), 0);
    end
    scan_en = 1'b0;
    chk("R8 diff_code kept", int'($signed(diff_code)), diff_m);
  endtask

  // R9 restart mid-conversion
  task automatic t_abort();
    run_conv(1'b0, 100, 3, 50);
    @(negedge clk);
    start = 1'b1; phase_sig = 1'b1; osr = 8'd100;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      start = 1'b0;
      mod_bit = 1'b1;
      if (i > 0) chk("R9 no done during aborted run", int'(done), 0);
    end
    run_conv(1'b1, 100, 0, 0);
    chk("R9 restart result", int'($signed(diff_code)), clamp_diff(-hold_m));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_patterns();
    t_saturate();
    t_osr_clamp();
    t_scan();
    t_abort();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule